// File: doc/BRIEF.md
# Four-Channel IPMI Mailbox Controller

This block sits on the management-processor side of a host link. It provides four keyboard-controller-style mailbox channels for IPMI traffic. Each channel has an input data word written by the host, an output data word written by local firmware, and a status word that carries the input-full and output-full flags. Local firmware reaches every word of a 0x260-byte register window over a 32-bit local request port. The host reaches only the three mailbox words of a channel, through a separate request port.

Each channel has its own enable bits. Channel 3 needs two enable bits set at once. Each channel also has an input-full interrupt enable, and that enable only works while its channel is enabled. When the host writes a channel's input word, the input-full flag is set, and the channel's interrupt flop is raised if the interrupt is allowed. The flop stays high until firmware reads that input word. A shared interrupt line is high while any bit of a five-entry pending mask is set. The mask holds the four channel interrupts and one external block-transfer interrupt level.

Both request ports use valid/ready handshakes, and `ready` is always high: every request with `valid` high is taken in that cycle. Read data comes back with a one-cycle `rvalid` pulse exactly one cycle after the request. The response has no back-pressure, so the requester must accept it in that cycle.

Top module: `kcs_mailbox_ctrl`

## Requirements
- R1: On reset every word of the window reads zero, except word 0x22 (byte offset 0x88), which reads the parameter CFG_INIT. All interrupt outputs are low.
- R2: A local write to a word index below 152 (window of 0x260 bytes) stores the 32-bit data. A local read returns the stored word. A read of an index at or above 152 returns zero, and a write there is dropped.
- R3: A host write with select 0 (input word) to channel c stores the data in that channel's input word and sets bit 1 (input full) of its status word. The input words of channels 1 to 4 are at byte offsets 0x24, 0x28, 0x2C and 0x114. Host reads use select 0 for the input word, select 1 for the output word, select 2 for the status word, and select 3 returns zero.
- R4: A local read of a channel's input word clears its input-full flag. If the flag was set before the read, the channel interrupt drops.
- R5: A local write to a channel's output word sets bit 0 (output full) of its status word. A host read of that output word clears the flag. The output words are at byte offsets 0x30, 0x34, 0x38 and 0x118, and the status words are at 0x3C, 0x40, 0x44 and 0x11C.
- R6: Host writes with select 1, 2 or 3 change nothing that the local read port can observe.
- R7: Channel 1 is enabled by bit 5 of byte offset 0x00, and channel 2 by bit 6 of the same word. Channel 3 is enabled only when bit 7 of 0x00 and bit 2 of 0x10 are both set. Channel 4 is enabled by bit 0 of 0x100.
- R8: A host input-word write raises the channel interrupt in the next cycle only when the channel is enabled and its interrupt enable is set. The interrupt enables are bits 1, 2 and 3 of 0x08 for channels 1 to 3, and bit 1 of 0x100 for channel 4. The enable values used are those held before the write.
- R9: A channel interrupt stays high through any other traffic until a local read of that channel's input word.
- R10: `shared_irq` is the OR of the four channel interrupts and `bt_irq`, each sampled one cycle earlier.
- R11: When a host access and a local access update the same status flag in the same cycle, the host update wins. This also applies to the interrupt flop and to the input data word.
- R12: `lb_ready` and `host_ready` are always high. `lb_rvalid` and `host_rvalid` pulse exactly one cycle after a read request, and read data reflects the state from before that cycle's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lb_valid | input | 1 | Local request valid |
| lb_ready | output | 1 | Local request accepted (always high) |
| lb_write | input | 1 | Local request is a write |
| lb_addr | input | ADDR_W | Local word index |
| lb_wdata | input | 32 | Local write data |
| lb_rvalid | output | 1 | Local read response valid |
| lb_rdata | output | 32 | Local read data |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request accepted (always high) |
| host_write | input | 1 | Host request is a write |
| host_chan | input | 2 | Channel 0..3 (channels 1..4) |
| host_sel | input | 2 | 0 input word, 1 output word, 2 status word, 3 none |
| host_wdata | input | 32 | Host write data |
| host_rvalid | output | 1 | Host read response valid |
| host_rdata | output | 32 | Host read data |
| bt_irq | input | 1 | Block-transfer interrupt level |
| chan_irq | output | 4 | Per-channel interrupt levels |
| shared_irq | output | 1 | OR of the pending mask |

## Verification
The bench builds the block with ADDR_W = 8 and CFG_INIT = 0xA5C30F11. The 8-bit index reaches word 255, so indices 152 to 255 beyond the window can be driven and must read zero. The non-zero configuration value makes the reset load of word 0x22 distinguishable from a plain clear. Random traffic concentrates on the control, mailbox and configuration words. It is mixed with directed cases for channel 3's double enable and for same-cycle host/local conflicts on both flags.

// File: rtl/kcs_pkg.sv
package kcs_pkg;
  localparam int NCH    = 4;
  localparam int BIT_OB = 0;
  localparam int BIT_IB = 1;

  localparam int W_CTRL0 = 'h00 >> 2;
  localparam int W_IEN   = 'h08 >> 2;
  localparam int W_CTRL4 = 'h10 >> 2;
  localparam int W_CFG   = 'h88 >> 2;
  localparam int W_CH4   = 'h100 >> 2;

  typedef enum logic [1:0] {
    HSEL_IN  = 2'd0,
    HSEL_OUT = 2'd1,
    HSEL_ST  = 2'd2,
    HSEL_NIL = 2'd3
  } hsel_e;

  function automatic int in_word(input int c);
    case (c)
      0: return 'h24 >> 2;
      1: return 'h28 >> 2;
      2: return 'h2C >> 2;
      default: return 'h114 >> 2;
    endcase
  endfunction

  function automatic int out_word(input int c);
    case (c)
      0: return 'h30 >> 2;
      1: return 'h34 >> 2;
      2: return 'h38 >> 2;
      default: return 'h118 >> 2;
    endcase
  endfunction

  function automatic int st_word(input int c);
    case (c)
      0: return 'h3C >> 2;
      1: return 'h40 >> 2;
      2: return 'h44 >> 2;
      default: return 'h11C >> 2;
    endcase
  endfunction

  function automatic logic chan_on(input int c, input logic [31:0] c0,
                                   input logic [31:0] c4, input logic [31:0] cb);
    case (c)
      0: return c0[5];
      1: return c0[6];
      2: return c0[7] & c4[2];
      default: return cb[0];
    endcase
  endfunction

  function automatic logic chan_ie(input int c, input logic [31:0] ie,
                                   input logic [31:0] cb);
    case (c)
      0: return ie[1];
      1: return ie[2];
      2: return ie[3];
      default: return cb[1];
    endcase
  endfunction
endpackage

// File: rtl/kcs_chan_irq.sv
module kcs_chan_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic drop,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)     irq <= 1'b0;
    else if (raise) irq <= 1'b1;
    else if (drop)  irq <= 1'b0;
  end
endmodule

// File: rtl/kcs_irq_pending.sv
module kcs_irq_pending #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl,
  output logic            shared
);
  logic [NSRC-1:0] pend;
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= lvl;
  end
  assign shared = |pend;
endmodule

// File: rtl/kcs_mailbox_ctrl.sv
module kcs_mailbox_ctrl #(
  parameter int          ADDR_W    = 8,
  parameter int          WIN_BYTES = 'h260,
  parameter logic [31:0] CFG_INIT  = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lb_valid,
  output logic              lb_ready,
  input  logic              lb_write,
  input  logic [ADDR_W-1:0] lb_addr,
  input  logic [31:0]       lb_wdata,
  output logic              lb_rvalid,
  output logic [31:0]       lb_rdata,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_write,
  input  logic [1:0]        host_chan,
  input  logic [1:0]        host_sel,
  input  logic [31:0]       host_wdata,
  output logic              host_rvalid,
  output logic [31:0]       host_rdata,
  input  logic              bt_irq,
  output logic [3:0]        chan_irq,
  output logic              shared_irq
);
  import kcs_pkg::*;

  localparam int NWORDS = WIN_BYTES / 4;

  logic [31:0] regs [NWORDS];

  logic       lb_in_win;
  logic [3:0] l_in_rd, l_out_wr, h_in_wr, h_out_rd;
  logic [3:0] raise, drop;
  int         h_word;

  assign lb_ready   = 1'b1;
  assign host_ready = 1'b1;
  assign lb_in_win  = int'(lb_addr) < NWORDS;

  // per-channel decode and interrupt flop
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int IW = in_word(c);
    localparam int OW = out_word(c);
    localparam int SW = st_word(c);
    logic en, ie;
    assign en = chan_on(c, regs[W_CTRL0], regs[W_CTRL4], regs[W_CH4]);
    assign ie = chan_ie(c, regs[W_IEN], regs[W_CH4]);
    assign l_in_rd[c]  = lb_valid && !lb_write && int'(lb_addr) == IW;
    assign l_out_wr[c] = lb_valid &&  lb_write && int'(lb_addr) == OW;
    assign h_in_wr[c]  = host_valid &&  host_write && host_sel == HSEL_IN
                         && int'(host_chan) == c;
    assign h_out_rd[c] = host_valid && !host_write && host_sel == HSEL_OUT
                         && int'(host_chan) == c;
    assign raise[c] = h_in_wr[c] && en && ie;
    assign drop[c]  = l_in_rd[c] && regs[SW][BIT_IB];

    kcs_chan_irq u_irq (
      .clk  (clk),
      .rst_n(rst_n),
      .raise(raise[c]),
      .drop (drop[c]),
      .irq  (chan_irq[c])
    );
  end

  always_comb begin
    case (hsel_e'(host_sel))
      HSEL_IN:  h_word = in_word(int'(host_chan));
      HSEL_OUT: h_word = out_word(int'(host_chan));
      HSEL_ST:  h_word = st_word(int'(host_chan));
      default:  h_word = -1;
    endcase
  end

  // register window; later assignments (host) take priority
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) regs[i] <= '0;
      regs[W_CFG] <= CFG_INIT;
    end else begin
      if (lb_valid && lb_write && lb_in_win) regs[lb_addr] <= lb_wdata;
      for (int c = 0; c < NCH; c++) begin
        if (l_out_wr[c]) regs[st_word(c)][BIT_OB] <= 1'b1;
        if (l_in_rd[c])  regs[st_word(c)][BIT_IB] <= 1'b0;
      end
      for (int c = 0; c < NCH; c++) begin
        if (h_in_wr[c]) begin
          regs[in_word(c)]         <= host_wdata;
          regs[st_word(c)][BIT_IB] <= 1'b1;
        end
        if (h_out_rd[c]) regs[st_word(c)][BIT_OB] <= 1'b0;
      end
    end
  end

  // read responses, one cycle after request
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lb_rvalid   <= 1'b0;
      lb_rdata    <= '0;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      lb_rvalid   <= lb_valid && !lb_write;
      host_rvalid <= host_valid && !host_write;
      if (lb_valid && !lb_write)
        lb_rdata <= lb_in_win ? regs[lb_addr] : '0;
      if (host_valid && !host_write)
        host_rdata <= (h_word >= 0) ? regs[h_word] : '0;
    end
  end

  kcs_irq_pending #(.NSRC(NCH + 1)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   ({bt_irq, chan_irq}),
    .shared(shared_irq)
  );
endmodule

// File: rtl/kcs_mailbox_chk.sv
module kcs_mailbox_chk #(
  parameter int ADDR_W    = 8,
  parameter int WIN_BYTES = 'h260
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lb_valid,
  input logic              lb_write,
  input logic [ADDR_W-1:0] lb_addr,
  input logic              lb_rvalid,
  input logic [31:0]       lb_rdata,
  input logic              host_valid,
  input logic              host_write,
  input logic [1:0]        host_chan,
  input logic [1:0]        host_sel,
  input logic              host_rvalid,
  input logic              bt_irq,
  input logic [3:0]        chan_irq,
  input logic              shared_irq
);
  localparam int NWORDS = WIN_BYTES / 4;

  assert_lb_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_valid && !lb_write) |=> lb_rvalid);
  assert_lb_noresp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(lb_valid && !lb_write) |=> !lb_rvalid);
  assert_host_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_write) |=> host_rvalid);
  assert_outside_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_valid && !lb_write && int'(lb_addr) >= NWORDS) |=> lb_rdata == 32'h0);
  assert_shared_or_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> shared_irq == ($past(bt_irq) || $past(|chan_irq)));

  for (genvar c = 0; c < 4; c++) begin : g_c
    localparam int IW = kcs_pkg::in_word(c);
    assert_rise_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_irq[c]) |-> $past(host_valid && host_write && host_sel == 2'd0
                                   && int'(host_chan) == c));
    assert_fall_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_irq[c]) |-> $past(lb_valid && !lb_write && int'(lb_addr) == IW));
  end
endmodule

bind kcs_mailbox_ctrl kcs_mailbox_chk #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lb_valid(lb_valid), .lb_write(lb_write),
  .lb_addr(lb_addr), .lb_rvalid(lb_rvalid), .lb_rdata(lb_rdata),
  .host_valid(host_valid), .host_write(host_write), .host_chan(host_chan),
  .host_sel(host_sel), .host_rvalid(host_rvalid), .bt_irq(bt_irq),
  .chan_irq(chan_irq), .shared_irq(shared_irq)
);

// File: tb/sim_kcs_mailbox_ctrl.sv
module sim_kcs_mailbox_ctrl;
  localparam logic [31:0] CFG = 32'hA5C3_0F11;
  localparam int NW = 152;

  logic clk = 0, rst_n = 0;
  logic lb_valid = 0, lb_write = 0, host_valid = 0, host_write = 0, bt_irq = 0;
  logic [7:0]  lb_addr = 0;
  logic [31:0] lb_wdata = 0, host_wdata = 0;
  logic [1:0]  host_chan = 0, host_sel = 0;
  logic lb_ready, lb_rvalid, host_ready, host_rvalid, shared_irq;
  logic [31:0] lb_rdata, host_rdata;
  logic [3:0]  chan_irq;

  always #10 clk = ~clk;

  kcs_mailbox_ctrl #(.ADDR_W(8), .CFG_INIT(CFG)) u0 (.*);

  int total = 0, bad = 0;
  logic [31:0] m [NW];
  logic [3:0]  m_irq;

  function automatic int b_in(int c);  return c == 3 ? 69 : 9 + c;  endfunction
  function automatic int b_out(int c); return c == 3 ? 70 : 12 + c; endfunction
  function automatic int b_st(int c);  return c == 3 ? 71 : 15 + c; endfunction
  function automatic bit b_en(int c);
    case (c)
      0: return m[0][5];
      1: return m[0][6];
      2: return m[0][7] && m[4][2];
      default: return m[64][0];
    endcase
  endfunction
  function automatic bit b_ie(int c);
    return c == 3 ? m[64][1] : m[2][c+1];
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < NW; i++) m[i] = 0;
    m[34] = CFG; m_irq = 0;
  endtask

  task automatic m_step(bit lv, bit lw, int la, logic [31:0] ld,
                        bit hv, bit hw, int hc, int hs, logic [31:0] hd,
                        output logic [31:0] el, output logic [31:0] eh);
    bit en[4], ie[4];
    for (int c = 0; c < 4; c++) begin en[c] = b_en(c); ie[c] = b_ie(c); end
    el = (la < NW) ? m[la] : 0;
    case (hs)
      0: eh = m[b_in(hc)];
      1: eh = m[b_out(hc)];
      2: eh = m[b_st(hc)];
      default: eh = 0;
    endcase
    if (lv && lw && la < NW) m[la] = ld;
    for (int c = 0; c < 4; c++) begin
      if (lv && lw && la == b_out(c)) m[b_st(c)][0] = 1;
      if (lv && !lw && la == b_in(c)) begin
        if (m[b_st(c)][1]) m_irq[c] = 0;
        m[b_st(c)][1] = 0;
      end
    end
    if (hv && hw && hs == 0) begin
      m[b_in(hc)] = hd; m[b_st(hc)][1] = 1;
      if (en[hc] && ie[hc]) m_irq[hc] = 1;
    end
    if (hv && !hw && hs == 1) m[b_st(hc)][0] = 0;
  endtask

  task automatic cyc(bit lv, bit lw, int la, logic [31:0] ld,
                     bit hv, bit hw, int hc, int hs, logic [31:0] hd);
    lb_valid = lv; lb_write = lw; lb_addr = la[7:0]; lb_wdata = ld;
    host_valid = hv; host_write = hw; host_chan = hc[1:0]; host_sel = hs[1:0];
    host_wdata = hd;
    @(negedge clk);
    lb_valid = 0; host_valid = 0;
  endtask

  task automatic op(string tag, bit lv, bit lw, int la, logic [31:0] ld,
                    bit hv, bit hw, int hc, int hs, logic [31:0] hd);
    logic [31:0] el, eh;
    m_step(lv, lw, la, ld, hv, hw, hc, hs, hd, el, eh);
    cyc(lv, lw, la, ld, hv, hw, hc, hs, hd);
    if (lv && !lw) chk({tag, " local read"}, lb_rdata, el);
    if (hv && !hw) chk({tag, " host read"}, host_rdata, eh);
    chk({tag, " chan_irq"}, {28'h0, chan_irq}, {28'h0, m_irq});
  endtask

  task automatic lwr(string t, int a, logic [31:0] d); op(t, 1, 1, a, d, 0, 0, 0, 0, 0); endtask
  task automatic lrd(string t, int a); op(t, 1, 0, a, 0, 0, 0, 0, 0, 0); endtask
  task automatic hwr(string t, int c, int s, logic [31:0] d); op(t, 0, 0, 0, 0, 1, 1, c, s, d); endtask
  task automatic hrd(string t, int c, int s); op(t, 0, 0, 0, 0, 1, 0, c, s, 0); endtask
  task automatic idle(string t);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk({t, " shared_irq"}, {31'h0, shared_irq}, {31'h0, (|m_irq) | bt_irq});
    chk({t, " chan_irq idle"}, {28'h0, chan_irq}, {28'h0, m_irq});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 chan_irq", {28'h0, chan_irq}, 0);
    chk("R1 shared_irq", {31'h0, shared_irq}, 0);
    cyc(1, 0, 34, 0, 0, 0, 0, 0, 0); chk("R1 cfg word", lb_rdata, CFG);
    chk("R12 lb_rvalid", {31'h0, lb_rvalid}, 1);
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0); chk("R1 ctrl word", lb_rdata, 0);
    cyc(1, 0, 15, 0, 0, 0, 0, 0, 0); chk("R1 status word", lb_rdata, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R12 rvalid drops", {31'h0, lb_rvalid}, 0);
    chk("R12 ready", {30'h0, lb_ready, host_ready}, 3);
    // R2 window
    lwr("R2", 20, 32'hDEAD_0001); lrd("R2", 20);
    lwr("R2 outside", 200, 32'h1234_5678); lrd("R2 outside", 200);
    // R7/R8 channel 1
    lwr("R7", 0, 32'h20); lwr("R8", 2, 32'h2);
    hwr("R8 ch1 raise", 0, 0, 32'h41); hrd("R3 ch1 status", 0, 2);
    idle("R10");
    hwr("R7 ch2 disabled", 1, 0, 32'h42);
    lwr("R8", 2, 32'h6); hwr("R8 ie needs enable", 1, 0, 32'h43);
    // channel 3 double enable
    lwr("R7", 0, 32'hA0); lwr("R8", 2, 32'hA);
    hwr("R7 ch3 half enabled", 2, 0, 32'h51);
    lwr("R7", 4, 32'h4); hwr("R7 ch3 fully enabled", 2, 0, 32'h52);
    lwr("R7", 64, 32'h3); hwr("R8 ch4 raise", 3, 0, 32'h61);
    // R9 hold, R4 clear
    repeat (3) idle("R9");
    lrd("R9 other", 12); hrd("R9 other", 0, 1);
    lrd("R4 read ch1 input", 9); hrd("R4 ch1 status", 0, 2);
    lrd("R4 second read", 9);
    // R5 output word
    lwr("R5", 13, 32'h77); hrd("R5 status", 1, 2); hrd("R5 output", 1, 1);
    hrd("R5 status after", 1, 2);
    // R6 ignored host writes
    hwr("R6 status write", 1, 2, 32'hFF); lrd("R6 status", 16);
    hwr("R6 output write", 1, 1, 32'h99); lrd("R6 output", 13);
    hwr("R6 sel3 write", 1, 3, 32'h99); hrd("R3 sel3", 1, 3);
    // R11 same-cycle conflicts
    op("R11 input", 1, 0, 69, 0, 1, 1, 3, 0, 32'h62); hrd("R11 ch4 status", 3, 2);
    lrd("R11 ch4 data", 69);
    op("R11 output", 1, 1, 12, 32'h88, 1, 0, 0, 1, 0); lrd("R11 ch1 status", 15);
    // R10 external level
    lrd("R4", 11); lrd("R4", 69);
    bt_irq = 1; idle("R10 bt"); bt_irq = 0; idle("R10 bt off");
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int la, hc, hs, k;
      bit lv, lw, hv, hw;
      k = $urandom % 10;
      case (k)
        0: la = 0; 1: la = 2; 2: la = 4; 3: la = 64; 4: la = 34;
        5: la = 9 + $urandom % 9;
        6: la = 69 + $urandom % 3;
        default: la = $urandom % 256;
      endcase
      lv = ($urandom % 3) != 0; lw = $urandom % 2;
      hv = ($urandom % 3) != 0; hw = $urandom % 2;
      hc = $urandom % 4; hs = $urandom % 4;
      if (hw && ($urandom % 2)) hs = 0;
      if ((n % 50) == 0) bt_irq = $urandom % 2;
      op(hs == 1 ? "R5 rand" : (lw ? "R2 rand" : "R4 rand"),
         lv, lw, la, $urandom, hv, hw, hc, hs, $urandom);
      if ((n % 7) == 0) idle("R10 rand");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule